// File: doc/BRIEF.md
# Message-Signaled Interrupt Capture Controller

This block sits beside the inbound memory-write path of a PCIe root port. Every inbound write carries a 64-bit address and a 32-bit data word. The block compares the address with a 64-bit match address held in a register. A write that matches is a message-signaled interrupt. The low eight data bits of that write name one of 256 vectors, and the block latches that vector as pending. The vectors are arranged as eight groups of 32.

Software reaches the block through a 32-bit register port. Each group has three registers in a fixed stride of 12 bytes: an enable word, a mask word and a status word. The block reduces all pending, enabled and unmasked vectors to one registered level interrupt for the CPU. An interrupt handler reads each group's status, clears the bits it serves by writing ones to them, and leaves the other bits alone.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After reset, both match-address words read 0, every enable word reads 0x00000000, every mask word reads 0xFFFFFFFF, every status word reads 0, and `irq_o` is 0.
- R2: Register offset 0x820 holds bits [31:0] of the match address and offset 0x824 holds bits [63:32]. Both can be written, and a read returns the value last written.
- R3: The registers of group g (g = 0..7) start at 0x828 + 12*g. The enable word is at +0x0, the mask word at +0x4 and the status word at +0x8. Enable and mask writes store the full 32-bit word.
- R4: When `msg_valid` is high, the 64-bit `msg_addr` equals the match address and the vector is enabled, the status bit for that vector reads 1 after the next rising clock edge. Data bits [7:5] select the group and bits [4:0] select the bit within it.
- R5: A message is ignored when its address differs from the match address in any of the 64 bits, or when its vector's enable bit is 0.
- R6: Status bits are write-one-to-clear. Writing 1 to a status bit clears it. Writing 0 leaves the bit unchanged, and a register write never sets a status bit.
- R7: If a status clear and a new matching message for the same bit fall in the same cycle, the bit reads 1 afterwards.
- R8: `irq_o` is a registered OR, taken over all groups, of (status AND enable AND NOT mask). It goes high one clock cycle after the status bit is set, and it goes low one cycle after the last such bit clears or becomes masked.
- R9: A read from any offset that is not listed in R2 or R3 returns 0.
- R10: Data bits [31:8] of a message have no effect on which vector is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Inbound memory write present this cycle |
| msg_addr | input | 64 | Inbound write address |
| msg_data | input | 32 | Inbound write data; bits [7:0] name the vector |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq_o | output | 1 | Level interrupt to the CPU |

## Verification
Register reads are combinational. A message or register write that is driven before rising edge k appears in the status or enable words as soon as edge k has passed. The bench drives inputs on falling edges and samples one falling edge later. `irq_o` has one more register stage, so the bench checks that it is still low at the first falling edge after the set and high at the second. The same two-step check applies when a bit is cleared or masked. The bench sweeps all 256 vectors through set, interrupt and clear. It also covers the same-cycle clear and set case, masked vectors, disabled vectors and addresses that differ only in the upper word.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
   localparam int unsigned REG_AW       = 12;
   localparam int unsigned REG_DW       = 32;
   localparam int unsigned OFF_MATCH_LO = 'h820;
   localparam int unsigned OFF_MATCH_HI = 'h824;
   localparam int unsigned OFF_GRP0     = 'h828;
   localparam int unsigned GRP_STRIDE   = 12;
   localparam int unsigned SUB_EN       = 0;
   localparam int unsigned SUB_MASK     = 4;
   localparam int unsigned SUB_STAT     = 8;

   function automatic int unsigned grp_base(input int unsigned g);
      return OFF_GRP0 + g * GRP_STRIDE;
   endfunction
endpackage

// File: rtl/msi_match_decode.sv
module msi_match_decode
   import msi_cap_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = 8,
   parameter int unsigned GROUP_W    = 32,
   parameter int unsigned MADDR_W    = 64,
   parameter int unsigned MDATA_W    = 32
) (
   input  logic                          msg_valid,
   input  logic [MADDR_W-1:0]            msg_addr,
   input  logic [MDATA_W-1:0]            msg_data,
   input  logic [MADDR_W-1:0]            match_addr,
   output logic [NUM_GROUPS*GROUP_W-1:0] set_req
);
   localparam int unsigned BIT_W = $clog2(GROUP_W);
   localparam int unsigned IDX_W = $clog2(NUM_GROUPS * GROUP_W);

   logic             hit;
   logic [IDX_W-1:0] idx;

   assign hit = msg_valid && (msg_addr == match_addr);
   assign idx = msg_data[IDX_W-1:0];

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_sel
      always_comb begin
         set_req[g*GROUP_W +: GROUP_W] = '0;
         if (hit && (idx[IDX_W-1:BIT_W] == (IDX_W-BIT_W)'(g)))
            set_req[g*GROUP_W + int'(idx[BIT_W-1:0])] = 1'b1;
      end
   end
endmodule

// File: rtl/msi_vec_group.sv
module msi_vec_group
   import msi_cap_pkg::*;
#(
   parameter int unsigned GROUP_W = 32,
   parameter int unsigned BASE    = 'h828
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [REG_DW-1:0] reg_wdata,
   input  logic [GROUP_W-1:0] set_req,
   output logic [REG_DW-1:0] rd_data,
   output logic              pend_o,
   output logic              stat_any_o
);
   localparam logic [REG_AW-1:0] A_EN   = REG_AW'(BASE + SUB_EN);
   localparam logic [REG_AW-1:0] A_MASK = REG_AW'(BASE + SUB_MASK);
   localparam logic [REG_AW-1:0] A_STAT = REG_AW'(BASE + SUB_STAT);

   logic [GROUP_W-1:0] en_q, mask_q, stat_q;
   logic [GROUP_W-1:0] clr, set_ok;

   assign clr    = (reg_wr && reg_addr == A_STAT) ? reg_wdata[GROUP_W-1:0] : '0;
   assign set_ok = set_req & en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= '0;
         mask_q <= '1;
         stat_q <= '0;
      end else begin
         if (reg_wr && reg_addr == A_EN)   en_q   <= reg_wdata[GROUP_W-1:0];
         if (reg_wr && reg_addr == A_MASK) mask_q <= reg_wdata[GROUP_W-1:0];
         stat_q <= (stat_q & ~clr) | set_ok;
      end
   end

   always_comb begin
      rd_data = '0;
      if (reg_addr == A_EN)        rd_data[GROUP_W-1:0] = en_q;
      else if (reg_addr == A_MASK) rd_data[GROUP_W-1:0] = mask_q;
      else if (reg_addr == A_STAT) rd_data[GROUP_W-1:0] = stat_q;
   end

   assign pend_o     = |(stat_q & en_q & ~mask_q);
   assign stat_any_o = |stat_q;

   // R1: reset leaves all three words at their defined values
   assert_reset_vals_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (en_q == '0 && mask_q == '1 && stat_q == '0));

   // R4 and R7: an accepted message sets its bit, even against a clear
   assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(set_req & en_q)) |=> ((stat_q & $past(set_req & en_q)) == $past(set_req & en_q)));

   // R5: no status bit rises unless it was enabled
   assert_gate_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(en_q)) == '0));

   // R6: bits written with one and not re-set are cleared
   assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_STAT) |=>
         ((stat_q & $past(reg_wdata[GROUP_W-1:0] & ~set_req)) == '0));
endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
   import msi_cap_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = 8,
   parameter int unsigned GROUP_W    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              msg_valid,
   input  logic [63:0]       msg_addr,
   input  logic [31:0]       msg_data,
   input  logic              reg_wr,
   input  logic [11:0]       reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq_o
);
   localparam int unsigned NVEC = NUM_GROUPS * GROUP_W;

   if (GROUP_W != REG_DW) begin : g_chk_w
      $error("GROUP_W must equal the register width");
   end
   if (NUM_GROUPS < 2 || (NUM_GROUPS & (NUM_GROUPS - 1)) != 0) begin : g_chk_n
      $error("NUM_GROUPS must be a power of two, at least 2");
   end
   if (NVEC > 256) begin : g_chk_v
      $error("vector index is limited to the low eight data bits");
   end

   logic [31:0]           match_lo_q, match_hi_q;
   logic [NVEC-1:0]       set_req;
   logic [NUM_GROUPS-1:0] pend, stat_any;
   logic [31:0]           grp_rd [NUM_GROUPS];
   logic                  irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         match_lo_q <= '0;
         match_hi_q <= '0;
      end else if (reg_wr) begin
         if (reg_addr == REG_AW'(OFF_MATCH_LO)) match_lo_q <= reg_wdata;
         if (reg_addr == REG_AW'(OFF_MATCH_HI)) match_hi_q <= reg_wdata;
      end
   end

   msi_match_decode #(
      .NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W), .MADDR_W(64), .MDATA_W(32)
   ) u_dec (
      .msg_valid (msg_valid),
      .msg_addr  (msg_addr),
      .msg_data  (msg_data),
      .match_addr({match_hi_q, match_lo_q}),
      .set_req   (set_req)
   );

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      msi_vec_group #(.GROUP_W(GROUP_W), .BASE(grp_base(g))) u_grp (
         .clk       (clk),
         .rst_n     (rst_n),
         .reg_wr    (reg_wr),
         .reg_addr  (reg_addr),
         .reg_wdata (reg_wdata),
         .set_req   (set_req[g*GROUP_W +: GROUP_W]),
         .rd_data   (grp_rd[g]),
         .pend_o    (pend[g]),
         .stat_any_o(stat_any[g])
      );
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == REG_AW'(OFF_MATCH_LO))      reg_rdata = match_lo_q;
      else if (reg_addr == REG_AW'(OFF_MATCH_HI)) reg_rdata = match_hi_q;
      for (int g = 0; g < NUM_GROUPS; g++) reg_rdata |= grp_rd[g];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |pend;
   end
   assign irq_o = irq_q;

   // R8: the interrupt is only raised on behalf of a latched status bit
   assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> $past(|stat_any));

   // R9: an unmapped offset reads as zero
   assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr < REG_AW'(OFF_MATCH_LO) ||
       reg_addr >= REG_AW'(grp_base(NUM_GROUPS))) |-> (reg_rdata == '0));
endmodule

// File: tb/test_msi_capture_ctrl.sv
module test_msi_capture_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam logic [63:0] MADDR = 64'h0000_0000_1000_0050;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        msg_valid = 1'b0;
   logic [63:0] msg_addr = '0;
   logic [31:0] msg_data = '0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   msi_capture_ctrl i_msi_capture_ctrl (
      .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_addr(msg_addr),
      .msg_data(msg_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
   );

   function automatic logic [11:0] goff(input int g, input int sub);
      return 12'(12'h828 + 12 * g + sub);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic send(input logic [63:0] a, input logic [31:0] d);
      @(negedge clk);
      msg_valid = 1'b1; msg_addr = a; msg_data = d;
      @(negedge clk);
      msg_valid = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state, R3 layout
      rd(12'h820, v); chk("R1 match lo", v, 32'h0);
      rd(12'h824, v); chk("R1 match hi", v, 32'h0);
      for (int g = 0; g < 8; g++) begin
         rd(goff(g, 0), v); chk("R1 enable", v, 32'h0);
         rd(goff(g, 4), v); chk("R1 mask", v, 32'hFFFF_FFFF);
         rd(goff(g, 8), v); chk("R1 status", v, 32'h0);
      end
      chk("R1 irq", {31'b0, irq_o}, 32'h0);

      // R2 match address
      wr(12'h820, MADDR[31:0]);
      wr(12'h824, MADDR[63:32]);
      rd(12'h820, v); chk("R2 match lo", v, 32'h1000_0050);
      rd(12'h824, v); chk("R2 match hi", v, 32'h0);

      // R9 unmapped offsets
      rd(12'h000, v); chk("R9 0x000", v, 32'h0);
      rd(12'h81C, v); chk("R9 0x81C", v, 32'h0);
      rd(12'h888, v); chk("R9 0x888", v, 32'h0);
      rd(12'h822, v); chk("R9 0x822", v, 32'h0);
      rd(12'hFFC, v); chk("R9 0xFFC", v, 32'h0);

      // R5 all vectors disabled
      send(MADDR, 32'd5);
      rd(goff(0, 8), v); chk("R5 disabled vector", v, 32'h0);

      // R3 enable and mask words per group
      for (int g = 0; g < 8; g++) begin
         wr(goff(g, 0), 32'hFFFF_FFFF);
         wr(goff(g, 4), 32'h0000_0000);
         rd(goff(g, 0), v); chk("R3 enable readback", v, 32'hFFFF_FFFF);
         rd(goff(g, 4), v); chk("R3 mask readback", v, 32'h0);
      end
      wr(goff(3, 4), 32'h1234_5678);
      rd(goff(3, 4), v); chk("R3 mask pattern", v, 32'h1234_5678);
      wr(goff(3, 4), 32'h0);

      // R4, R8, R10, R6 sweep over all 256 vectors
      for (int n = 0; n < 256; n++) begin
         send(MADDR, (32'hA5A5_A500 ^ (32'(n) << 9)) | 32'(n));
         #1 chk("R8 irq not before one cycle", {31'b0, irq_o}, 32'h0);
         rd(goff(n / 32, 8), v);
         chk("R4 R10 status bit", v, 32'h1 << (n % 32));
         #1 chk("R8 irq after one cycle", {31'b0, irq_o}, 32'h1);
         wr(goff(n / 32, 8), 32'h1 << (n % 32));
         #1 chk("R6 status cleared", reg_rdata, 32'h0);
         @(negedge clk);
         #1 chk("R8 irq drops", {31'b0, irq_o}, 32'h0);
      end

      // R5 address mismatch in low word and in high word
      send(MADDR + 64'd4, 32'd7);
      send(MADDR | 64'h1_0000_0000, 32'd7);
      rd(goff(0, 8), v); chk("R5 address mismatch", v, 32'h0);

      // R5 one vector disabled among enabled ones
      wr(goff(0, 0), 32'hFFFF_FBFF);
      send(MADDR, 32'd10);
      rd(goff(0, 8), v); chk("R5 disabled bit 10", v, 32'h0);
      wr(goff(0, 0), 32'hFFFF_FFFF);

      // R8 masked vector gives no interrupt
      wr(goff(2, 4), 32'h0000_0008);
      send(MADDR, 32'd67);
      @(negedge clk);
      rd(goff(2, 8), v); chk("R8 masked status set", v, 32'h8);
      chk("R8 masked irq low", {31'b0, irq_o}, 32'h0);
      wr(goff(2, 4), 32'h0);
      #1 chk("R8 unmask not yet", {31'b0, irq_o}, 32'h0);
      @(negedge clk);
      #1 chk("R8 unmask irq high", {31'b0, irq_o}, 32'h1);
      wr(goff(2, 8), 32'h8);

      // R6 partial clear, zeros leave bits alone
      send(MADDR, 32'd64);
      send(MADDR, 32'd65);
      wr(goff(2, 8), 32'h1);
      rd(goff(2, 8), v); chk("R6 partial clear", v, 32'h2);
      wr(goff(2, 8), 32'h0);
      rd(goff(2, 8), v); chk("R6 zero write", v, 32'h2);
      wr(goff(2, 8), 32'hFFFF_FFFF);
      rd(goff(2, 8), v); chk("R6 all clear no set", v, 32'h0);

      // R7 clear and set of the same bit in one cycle
      send(MADDR, 32'd66);
      @(negedge clk);
      msg_valid = 1'b1; msg_addr = MADDR; msg_data = 32'd66;
      reg_wr = 1'b1; reg_addr = goff(2, 8); reg_wdata = 32'h4;
      @(negedge clk);
      msg_valid = 1'b0; reg_wr = 1'b0;
      rd(goff(2, 8), v); chk("R7 set wins", v, 32'h4);
      wr(goff(2, 8), 32'h4);
      rd(goff(2, 8), v); chk("R7 later clear", v, 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule